// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block collects interrupt events for a host-side link controller and reduces them to one interrupt line. Legacy line-interrupt assert and deassert pulses, plus power-state-change and flush pulses, latch into two core status registers. Message-signalled interrupt writes arrive on a small write port that carries a vector index and a payload. Each write sets one bit of a 32-vector message status register and captures the low byte of the payload. Any unmasked message vector sets a single "message pending" bit in the core status register. Any unmasked core bit drives a live summary bit, bit 16, in a top-level status register. That register also latches a set of external summary event pulses. The output line is the OR of all unmasked top-level bits.

Software uses a simple register port. Every status register is write-one-to-clear, and each has a companion mask in which a set bit blocks the source. Two plain read/write registers hold the message target address. Both streaming inputs (the message write port and the register request port) use valid/ready, and their ready outputs are tied high. Neither port ever applies back-pressure: a beat is accepted in every cycle in which valid is high. A read answers with `rsp_valid_o` exactly one cycle after it is accepted. Writes produce no response.

Word address map: 0 core status, 1 core mask, 2 auxiliary status, 3 auxiliary mask, 4 message status, 5 message mask, 6 captured payload (read-only), 7 target address low, 8 target address high, 9 top status, 10 top mask. Unmapped addresses read 0.

Top module: `intr_agg_top`

## Requirements
- R1: After reset all status registers read 0, `irq_o` is low, and every mask reads all-ones over its implemented bits: core 0x7FFFFFF, auxiliary 0x30, message 0xFFFFFFFF, top 0xFFF0FB.
- R2: An assert pulse on line n (n = 0..3) sets core status bit 16+n, and a deassert pulse sets bit 20+n. The bit is visible from the clock edge that samples the pulse.
- R3: Writing a status register clears each bit written as 1 and leaves the bits written as 0 unchanged. Bits outside the implemented set always read 0.
- R4: When an event and a software clear hit the same status bit in the same cycle, the event wins and the bit stays set.
- R5: An accepted message write to vector v sets message status bit v, even when that vector is masked. It also loads the low 8 bits of the payload into the payload register (address 6). `msi_ready_o` is always 1.
- R6: Core bit 24 sets one edge after any message status bit is set with its mask bit clear. Clearing the message status does not clear bit 24. Only a write of 1 to bit 24 clears it, and only when no unmasked message vector remains.
- R7: A power-state-change pulse sets auxiliary status bit 4, and a flush pulse sets bit 5.
- R8: Top status bit 16 reads 1 exactly while any core or auxiliary status bit is set with its mask clear. Writes to that bit have no effect.
- R9: `irq_o` is the OR of top status bits whose top mask bit is clear. Mask bits exist only at the positions set in 0xFFF0FB.
- R10: The target address low and high registers are plain 32-bit read/write registers that reset to 0.
- R11: `req_ready_o` is always 1. A read returns `rsp_valid_o` with the register value one cycle after acceptance, and unmapped addresses return 0.
- R12: An external summary pulse on bit k sets top status bit k when k is one of the positions in 0xFFF0FB other than 16. Those bits are write-one-to-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| intx_assert_i | input | 4 | Legacy line assert pulses |
| intx_deassert_i | input | 4 | Legacy line deassert pulses |
| pm_change_i | input | 1 | Power-state-change pulse |
| flush_i | input | 1 | Flush event pulse |
| ext_evt_i | input | 24 | External top-level summary pulses |
| msi_valid_i | input | 1 | Message write valid |
| msi_ready_o | output | 1 | Message write ready (always 1) |
| msi_vec_i | input | 5 | Message vector index |
| msi_data_i | input | 16 | Message payload |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request ready (always 1) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 4 | Register word address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Interrupt line |

## Verification
Each latch takes one edge: event pulses, message writes and register writes show up in the status registers one edge after they are sampled. Core bit 24 takes one more edge, because it is set from the registered message status. The top summary bit and `irq_o` are combinational from the registers, so they follow a status or mask change without added delay. A read snapshots the registers at its acceptance edge and answers one cycle later. For that reason the bench idles one cycle after every write or pulse before it reads, and it samples `irq_o` and every response on the falling edge. The monitor also requires a read response to appear exactly one cycle after the request.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;
  localparam int DATA_W       = 32;
  localparam int ADDR_W       = 4;
  localparam int INTX_N       = 4;
  localparam int CORE_W       = 27;
  localparam int AUX_W        = 6;
  localparam int TOP_W        = 24;
  localparam int INTX_AS_LSB  = 16;
  localparam int INTX_DE_LSB  = 20;
  localparam int MSI_PEND_BIT = 24;
  localparam int AUX_PM_BIT   = 4;
  localparam int AUX_FL_BIT   = 5;
  localparam int TOP_CORE_BIT = 16;
  localparam logic [CORE_W-1:0] CORE_VALID = {CORE_W{1'b1}};
  localparam logic [AUX_W-1:0]  AUX_VALID  = 6'h30;
  localparam logic [TOP_W-1:0]  TOP_VALID  = 24'hFFF0FB;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CORE_STAT = 4'd0,
    SEL_CORE_MASK = 4'd1,
    SEL_AUX_STAT  = 4'd2,
    SEL_AUX_MASK  = 4'd3,
    SEL_MSI_STAT  = 4'd4,
    SEL_MSI_MASK  = 4'd5,
    SEL_MSI_PAY   = 4'd6,
    SEL_TGT_LO    = 4'd7,
    SEL_TGT_HI    = 4'd8,
    SEL_TOP_STAT  = 4'd9,
    SEL_TOP_MASK  = 4'd10
  } reg_sel_e;
endpackage

// File: rtl/intr_w1c_bank.sv
module intr_w1c_bank #(
  parameter int            W        = 8,
  parameter logic [W-1:0]  VALID    = {W{1'b1}},
  parameter logic [W-1:0]  MASK_RST = {W{1'b1}}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         pend_o
);
  logic [W-1:0] clr_vec;

  assign clr_vec = clr_we_i ? wdata_i : '0;

  // event set takes priority over the software clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_o <= '0;
      mask_o <= MASK_RST & VALID;
    end else begin
      stat_o <= ((stat_o & ~clr_vec) | evt_i) & VALID;
      if (mask_we_i) mask_o <= wdata_i & VALID;
    end
  end

  assign pend_o = |(stat_o & ~mask_o);

  p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & VALID)) |=> ((stat_o & $past(evt_i & VALID)) == $past(evt_i & VALID)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((stat_o & $past(wdata_i & ~evt_i & VALID)) == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we_i && evt_i == '0) |=> (stat_o == $past(stat_o)));
endmodule

// File: rtl/intr_msi_intake.sv
module intr_msi_intake #(
  parameter int N     = 32,
  parameter int PAY_W = 16,
  parameter int CAP_W = 8,
  localparam int VW   = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [VW-1:0]    vec_i,
  input  logic [PAY_W-1:0] data_i,
  output logic [N-1:0]     evt_o,
  output logic [CAP_W-1:0] cap_o
);
  assign ready_o = 1'b1;

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign evt_o[g] = valid_i && (vec_i == VW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cap_o <= '0;
    else if (valid_i) cap_o <= data_i[CAP_W-1:0];
  end

  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (cap_o == $past(data_i[CAP_W-1:0])));
endmodule

// File: rtl/intr_agg_top.sv
module intr_agg_top
  import intr_agg_pkg::*;
#(
  parameter int MSI_N = 32,
  parameter int PAY_W = 16,
  parameter int CAP_W = 8,
  localparam int VW   = $clog2(MSI_N)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [INTX_N-1:0]     intx_assert_i,
  input  logic [INTX_N-1:0]     intx_deassert_i,
  input  logic                  pm_change_i,
  input  logic                  flush_i,
  input  logic [TOP_W-1:0]      ext_evt_i,
  input  logic                  msi_valid_i,
  output logic                  msi_ready_o,
  input  logic [VW-1:0]         msi_vec_i,
  input  logic [PAY_W-1:0]      msi_data_i,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic                  req_write_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [DATA_W-1:0]     req_wdata_i,
  output logic                  rsp_valid_o,
  output logic [DATA_W-1:0]     rsp_rdata_o,
  output logic                  irq_o
);
  logic              wr, rd;
  logic [MSI_N-1:0]  msi_evt, msi_stat, msi_mask;
  logic [CAP_W-1:0]  msi_cap;
  logic              msi_pend;
  logic [CORE_W-1:0] core_evt, core_stat, core_mask;
  logic              core_pend;
  logic [AUX_W-1:0]  aux_evt, aux_stat, aux_mask;
  logic              aux_pend;
  logic [TOP_W-1:0]  top_evt, top_stat, top_mask, top_view;
  logic              top_pend_unused;
  logic              core_sum;
  logic [DATA_W-1:0] tgt_lo, tgt_hi, rd_mux;

  assign req_ready_o = 1'b1;
  assign wr = req_valid_i && req_write_i;
  assign rd = req_valid_i && !req_write_i;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_sel_e s);
    return a == s;
  endfunction

  intr_msi_intake #(.N(MSI_N), .PAY_W(PAY_W), .CAP_W(CAP_W)) u_msi_in (
    .clk(clk), .rst_n(rst_n), .valid_i(msi_valid_i), .ready_o(msi_ready_o),
    .vec_i(msi_vec_i), .data_i(msi_data_i), .evt_o(msi_evt), .cap_o(msi_cap));

  intr_w1c_bank #(.W(MSI_N), .VALID({MSI_N{1'b1}}), .MASK_RST({MSI_N{1'b1}})) u_msi (
    .clk(clk), .rst_n(rst_n), .evt_i(msi_evt),
    .clr_we_i(wr && hit(req_addr_i, SEL_MSI_STAT)),
    .mask_we_i(wr && hit(req_addr_i, SEL_MSI_MASK)),
    .wdata_i(req_wdata_i[MSI_N-1:0]), .stat_o(msi_stat), .mask_o(msi_mask), .pend_o(msi_pend));

  always_comb begin
    core_evt = '0;
    core_evt[INTX_AS_LSB +: INTX_N] = intx_assert_i;
    core_evt[INTX_DE_LSB +: INTX_N] = intx_deassert_i;
    core_evt[MSI_PEND_BIT]          = msi_pend;
    aux_evt = '0;
    aux_evt[AUX_PM_BIT] = pm_change_i;
    aux_evt[AUX_FL_BIT] = flush_i;
    top_evt = ext_evt_i;
    top_evt[TOP_CORE_BIT] = 1'b0;
  end

  intr_w1c_bank #(.W(CORE_W), .VALID(CORE_VALID), .MASK_RST(CORE_VALID)) u_core (
    .clk(clk), .rst_n(rst_n), .evt_i(core_evt),
    .clr_we_i(wr && hit(req_addr_i, SEL_CORE_STAT)),
    .mask_we_i(wr && hit(req_addr_i, SEL_CORE_MASK)),
    .wdata_i(req_wdata_i[CORE_W-1:0]), .stat_o(core_stat), .mask_o(core_mask), .pend_o(core_pend));

  intr_w1c_bank #(.W(AUX_W), .VALID(AUX_VALID), .MASK_RST(AUX_VALID)) u_aux (
    .clk(clk), .rst_n(rst_n), .evt_i(aux_evt),
    .clr_we_i(wr && hit(req_addr_i, SEL_AUX_STAT)),
    .mask_we_i(wr && hit(req_addr_i, SEL_AUX_MASK)),
    .wdata_i(req_wdata_i[AUX_W-1:0]), .stat_o(aux_stat), .mask_o(aux_mask), .pend_o(aux_pend));

  intr_w1c_bank #(.W(TOP_W), .VALID(TOP_VALID), .MASK_RST(TOP_VALID)) u_top (
    .clk(clk), .rst_n(rst_n), .evt_i(top_evt),
    .clr_we_i(wr && hit(req_addr_i, SEL_TOP_STAT)),
    .mask_we_i(wr && hit(req_addr_i, SEL_TOP_MASK)),
    .wdata_i(req_wdata_i[TOP_W-1:0]), .stat_o(top_stat), .mask_o(top_mask), .pend_o(top_pend_unused));

  assign core_sum = core_pend | aux_pend;

  always_comb begin
    top_view = top_stat;
    top_view[TOP_CORE_BIT] = core_sum;
  end

  assign irq_o = |(top_view & ~top_mask & TOP_VALID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_lo <= '0;
      tgt_hi <= '0;
    end else begin
      if (wr && hit(req_addr_i, SEL_TGT_LO)) tgt_lo <= req_wdata_i;
      if (wr && hit(req_addr_i, SEL_TGT_HI)) tgt_hi <= req_wdata_i;
    end
  end

  always_comb begin
    unique case (req_addr_i)
      SEL_CORE_STAT: rd_mux = DATA_W'(core_stat);
      SEL_CORE_MASK: rd_mux = DATA_W'(core_mask);
      SEL_AUX_STAT:  rd_mux = DATA_W'(aux_stat);
      SEL_AUX_MASK:  rd_mux = DATA_W'(aux_mask);
      SEL_MSI_STAT:  rd_mux = DATA_W'(msi_stat);
      SEL_MSI_MASK:  rd_mux = DATA_W'(msi_mask);
      SEL_MSI_PAY:   rd_mux = DATA_W'(msi_cap);
      SEL_TGT_LO:    rd_mux = tgt_lo;
      SEL_TGT_HI:    rd_mux = tgt_hi;
      SEL_TOP_STAT:  rd_mux = DATA_W'(top_view);
      SEL_TOP_MASK:  rd_mux = DATA_W'(top_mask);
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd;
      if (rd) rsp_rdata_o <= rd_mux;
    end
  end

  p_msi_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pend |=> core_stat[MSI_PEND_BIT]);

  p_core_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(aux_stat & ~aux_mask)) |-> top_view[TOP_CORE_BIT]);

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (top_mask == TOP_VALID) |-> !irq_o);

  p_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid_o);

  p_tgt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit(req_addr_i, SEL_TGT_LO)) |=> (tgt_lo == $past(req_wdata_i)));
endmodule

// File: tb/tb_intr_agg_top.sv
`timescale 1ns/1ps
module tb_intr_agg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  intx_assert = '0, intx_deassert = '0;
  logic        pm_change = 1'b0, flush = 1'b0;
  logic [23:0] ext_evt = '0;
  logic        msi_valid = 1'b0;
  logic        msi_ready;
  logic [4:0]  msi_vec = '0;
  logic [15:0] msi_data = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  intr_agg_top dut (
    .clk(clk), .rst_n(rst_n), .intx_assert_i(intx_assert), .intx_deassert_i(intx_deassert),
    .pm_change_i(pm_change), .flush_i(flush), .ext_evt_i(ext_evt),
    .msi_valid_i(msi_valid), .msi_ready_o(msi_ready), .msi_vec_i(msi_vec), .msi_data_i(msi_data),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .irq_o(irq));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check(32'h1, 32'h0, "R11 unexpected response");
      else check(rsp_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    idle(1);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
    check(32'(rsp_valid), 32'h1, "R11 response one cycle after read");
  endtask

  task automatic msi_send(input logic [4:0] v, input logic [15:0] d);
    msi_valid = 1'b1; msi_vec = v; msi_data = d;
    @(negedge clk);
    msi_valid = 1'b0;
    idle(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check(32'(irq), 32'h0, "R1 irq after reset");
    rd(4'd0, 32'h0, "R1 core status");
    rd(4'd1, 32'h07FF_FFFF, "R1 core mask");
    rd(4'd3, 32'h30, "R1 aux mask");
    rd(4'd5, 32'hFFFF_FFFF, "R1 msi mask");
    rd(4'd10, 32'h00FF_F0FB, "R1 top mask");
    rd(4'd7, 32'h0, "R10 target low reset");
    check(32'(msi_ready & req_ready), 32'h1, "R5 R11 ready high");
    rd(4'd15, 32'h0, "R11 unmapped address");

    // R2 line events
    intx_assert = 4'b0101; intx_deassert = 4'b1000;
    @(negedge clk);
    intx_assert = '0; intx_deassert = '0;
    idle(1);
    rd(4'd0, 32'h0085_0000, "R2 assert/deassert bits");
    rd(4'd9, 32'h0, "R8 masked core gives no summary");

    // R3 write one to clear
    wr(4'd0, 32'h0001_0000);
    rd(4'd0, 32'h0084_0000, "R3 clear bit16");
    wr(4'd0, 32'h0);
    rd(4'd0, 32'h0084_0000, "R3 zero write keeps bits");

    // R8 / R9 summary and line
    wr(4'd1, 32'h07FB_FFFF);
    rd(4'd9, 32'h0001_0000, "R8 summary bit16 set");
    check(32'(irq), 32'h0, "R9 top mask blocks irq");
    wr(4'd10, 32'h00FE_F0FB);
    check(32'(irq), 32'h1, "R9 irq with bit16 unmasked");
    wr(4'd9, 32'h0001_0000);
    rd(4'd9, 32'h0001_0000, "R8 write to summary ignored");
    wr(4'd0, 32'h0004_0000);
    check(32'(irq), 32'h0, "R9 irq drops after core clear");
    rd(4'd9, 32'h0, "R8 summary clears with source");

    // R4 event beats clear
    intx_assert = 4'b0010;
    @(negedge clk);
    intx_assert = '0;
    idle(1);
    rd(4'd0, 32'h0082_0000, "R2 bit17 set");
    intx_assert = 4'b0010;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd0; req_wdata = 32'h0082_0000;
    @(negedge clk);
    intx_assert = '0; req_valid = 1'b0; req_write = 1'b0;
    idle(1);
    rd(4'd0, 32'h0002_0000, "R4 event wins over clear");

    // R5 / R6 message interrupts
    msi_send(5'd5, 16'h01A7);
    rd(4'd4, 32'h0000_0020, "R5 msi vector 5 status");
    rd(4'd6, 32'h0000_00A7, "R5 payload low byte");
    rd(4'd0, 32'h0002_0000, "R6 masked msi no pending");
    wr(4'd5, 32'hFFFF_FFDF);
    rd(4'd0, 32'h0102_0000, "R6 pending bit24 set");
    wr(4'd4, 32'h0000_0020);
    rd(4'd4, 32'h0, "R5 msi status cleared");
    rd(4'd0, 32'h0102_0000, "R6 pending survives msi clear");
    wr(4'd0, 32'h0100_0000);
    rd(4'd0, 32'h0002_0000, "R6 pending cleared by w1c");
    msi_send(5'd31, 16'hFF3C);
    idle(1);
    rd(4'd4, 32'h8000_0000, "R5 masked vector 31 records");
    rd(4'd6, 32'h0000_003C, "R5 payload updated");
    rd(4'd0, 32'h0002_0000, "R6 masked vector no pending");

    // R7 auxiliary events
    wr(4'd0, 32'h0002_0000);
    rd(4'd9, 32'h0, "R8 summary quiet");
    check(32'(irq), 32'h0, "R9 irq quiet");
    pm_change = 1'b1; flush = 1'b1;
    @(negedge clk);
    pm_change = 1'b0; flush = 1'b0;
    idle(1);
    rd(4'd2, 32'h30, "R7 power and flush bits");
    wr(4'd2, 32'h10);
    rd(4'd2, 32'h20, "R7 R3 clear power bit");
    wr(4'd3, 32'h10);
    rd(4'd9, 32'h0001_0000, "R8 aux feeds summary");
    check(32'(irq), 32'h1, "R9 irq from aux");
    wr(4'd2, 32'h20);
    check(32'(irq), 32'h0, "R9 irq after aux clear");

    // R12 external summary events
    ext_evt = 24'h01_0F0F;
    @(negedge clk);
    ext_evt = '0;
    idle(1);
    rd(4'd9, 32'h0000_000B, "R12 latch at valid positions");
    check(32'(irq), 32'h0, "R9 ext bits masked");
    wr(4'd10, 32'h00FE_F0F3);
    check(32'(irq), 32'h1, "R9 R12 unmasked bit3");
    wr(4'd9, 32'h8);
    rd(4'd9, 32'h3, "R12 w1c ext bit");
    check(32'(irq), 32'h0, "R9 irq after ext clear");

    // R10 target address
    wr(4'd7, 32'hDEAD_BEEF);
    wr(4'd8, 32'h1234_5678);
    rd(4'd7, 32'hDEAD_BEEF, "R10 target low");
    rd(4'd8, 32'h1234_5678, "R10 target high");

    idle(3);
    if (exp_q.size() != 0) check(32'(exp_q.size()), 32'h0, "R11 missing responses");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule